// File: doc/BRIEF.md
# Bridge Interrupt Status Controller

This block holds the control word and the status/capability word of a host bus bridge. Both are reached over a simple 32-bit register bus with a byte offset: offset 0x00 selects the control word and offset 0x04 selects the status word. Read data is returned one cycle after the read strobe and is held until the next read.

The block watches four active-low legacy interrupt pins. It also receives six single-cycle event pulses from the error and DMA logic, and two completion pulses from the configuration-access engine. The events are stored as sticky flags, and software clears a flag by writing a one to its position.

The pin levels, the per-pin mask and the enabled error flags are combined onto a set of registered interrupt outputs. Which outputs are used depends on a two-bit interrupt mode that is strapped at the boundary: either one shared line, or one line per pin, in each case with an optional separate DMA line. The control word also drives the bridge's bus-reset line and its bus-number, parity-enable and error-response settings.

Top module: `hbr_irq_csr`

## Requirements
- R1: A write to offset 0x00 stores bit 31 (bus reset), bit 27 (system-error interrupt enable), bit 26 (parity enable), bit 25 (error interrupt enable), bit 24 (error response enable), bits 23:16 (bus number) and bits 3:0 (per-pin enable mask, 1 = enabled). All other bits read as 0. After reset every bit is 0. A read returns the word on `bus_rdata` in the cycle after the read strobe, and a read of any other offset returns 0.
- R2: `bus_reset_o` equals control bit 31 from the cycle after the write that sets it, and stays high until a write clears the bit. `bus_num_o`, `par_en_o` and `err_resp_en_o` follow bits 23:16, 26 and 24.
- R3: A pulse on `ev_pulse_i[i]` sets status bit 12+i. The bits are: 12 parity error, 13 target abort, 14 master abort, 15 DMA error, 16 DMA done, 17 system error. A flag stays set until a write to offset 0x04 has a one at its position. A zero written there leaves the flag unchanged. If a set pulse and a clearing write arrive in the same cycle, the flag ends up set.
- R4: `cfg_done_i` sets status bit 20 and `cfg_err_i` sets status bit 19, with the same sticky and write-one-to-clear rules as R3.
- R5: Status bits 11:8 show the pin levels of `intx_n_i[3:0]` after a two-flop synchronizer. A pin change is first visible in the status word two clock edges later. After reset these bits read 1.
- R6: The read-only status fields never change when written. They are: bit 31 host-slot indicator, bit 30 master capable, bit 29 target capable, bit 28 DMA present, bit 23 trace present, bits 4:2 FIFO depth, bits 1:0 FIFO count (all set by parameters), and bits 25:24 equal to `irq_mode_i`. A write of all ones to offset 0x04 clears every sticky flag.
- R7: Pin n is pending when inverted status bit 8+n and control mask bit n are both 1.
- R8: The error condition is (system-error flag AND control bit 27) OR ((master abort OR target abort OR parity flag) AND control bit 25). The DMA condition is DMA done OR DMA error.
- R9: In mode 0, `irq_comb_o` = error OR any pending pin OR DMA condition. `irq_intx_o` and `irq_dma_o` are 0.
- R10: In mode 1, `irq_comb_o` = error OR any pending pin, and `irq_dma_o` = DMA condition. `irq_intx_o` is 0.
- R11: In mode 2, `irq_intx_o[0]` = pending 0 OR error OR DMA condition, and `irq_intx_o[n]` = pending n for n = 1..3. `irq_comb_o` and `irq_dma_o` are 0.
- R12: In mode 3, `irq_intx_o[0]` = pending 0 OR error, and `irq_intx_o[n]` = pending n for n = 1..3. `irq_dma_o` = DMA condition and `irq_comb_o` is 0.
- R13: All interrupt outputs are registered. Each output reflects, one cycle later, the flags, mask and synchronized levels that held at the previous edge, together with the mode sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_mode_i | input | 2 | Strapped interrupt mode |
| intx_n_i | input | 4 | Active-low legacy interrupt pins |
| ev_pulse_i | input | 6 | Event pulses for status bits 17:12 |
| cfg_done_i | input | 1 | Configuration access done pulse |
| cfg_err_i | input | 1 | Configuration access error pulse |
| irq_comb_o | output | 1 | Shared interrupt (modes 0, 1) |
| irq_intx_o | output | 4 | Per-pin interrupts (modes 2, 3) |
| irq_dma_o | output | 1 | Separate DMA interrupt (modes 1, 3) |
| bus_reset_o | output | 1 | Bus reset drive |
| bus_num_o | output | 8 | Bus number field |
| err_resp_en_o | output | 1 | Error response enable |
| par_en_o | output | 1 | Parity enable |

## Verification
The latencies the bench relies on are as follows. A read returns its data one edge after the strobe. An event pulse or a register write takes effect at the same edge it is sampled, so the interrupt lines react one edge after that. A pin change needs two edges to reach the status word and a third to reach the interrupt lines.

The bench holds a behavioural model that steps once per rising edge, taking its inputs from the previous falling edge. It compares every output at each falling edge, so each result is checked in exactly the cycle it is due. The failure tag is chosen from the active mode and from the status field being read back.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NINTX  = 4;
  localparam int unsigned NEV    = 6;
  localparam int unsigned NFLAG  = NEV + 2;

  // control word bit positions
  localparam int unsigned C_BUSRST = 31;
  localparam int unsigned C_SYSIE  = 27;
  localparam int unsigned C_PAREN  = 26;
  localparam int unsigned C_ERRIE  = 25;
  localparam int unsigned C_ERRRSP = 24;
  localparam int unsigned C_BUSLO  = 16;
  localparam logic [WORD_W-1:0] CTRL_MASK = 32'h8FFF_000F;

  // status word bit positions
  localparam int unsigned S_EVLO    = 12;
  localparam int unsigned S_LVLLO   = 8;
  localparam int unsigned S_CFGERR  = 19;
  localparam int unsigned S_CFGDONE = 20;

  // flag indices inside the sticky vector
  localparam int unsigned F_PAR  = 0;
  localparam int unsigned F_TGT  = 1;
  localparam int unsigned F_MST  = 2;
  localparam int unsigned F_DERR = 3;
  localparam int unsigned F_DONE = 4;
  localparam int unsigned F_SYS  = 5;
  localparam int unsigned F_CERR = 6;
  localparam int unsigned F_CDON = 7;

  typedef enum logic [1:0] {
    MODE_ONE_LINE   = 2'd0,
    MODE_ONE_PLUS_D = 2'd1,
    MODE_PER_PIN    = 2'd2,
    MODE_PIN_PLUS_D = 2'd3
  } irq_mode_e;
endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/hbr_sticky.sv
module hbr_sticky #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            flag_o[g] <= 1'b0;
      else if (set_i[g])  flag_o[g] <= 1'b1;
      else if (clr_i[g])  flag_o[g] <= 1'b0;
    end

    // R3 R4: a set pulse always lands, even against a clearing write
    p_set_r3: assert property (@(posedge clk) disable iff (rst)
      set_i[g] |=> flag_o[g]);
    // R3 R4: a one written clears the flag
    p_clr_r3: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
    // R3: without set or clear the flag keeps its value
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[g] && !set_i[g]) |=> flag_o[g] == $past(flag_o[g]));
  end
endmodule

// File: rtl/hbr_route.sv
module hbr_route
  import hbr_pkg::*;
#(
  parameter int unsigned NPIN = NINTX
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode_i,
  input  logic [NPIN-1:0] pend_i,
  input  logic            err_i,
  input  logic            dma_i,
  output logic            irq_comb_o,
  output logic [NPIN-1:0] irq_intx_o,
  output logic            irq_dma_o
);
  logic            comb_d;
  logic [NPIN-1:0] intx_d;
  logic            dma_d;

  always_comb begin
    comb_d = 1'b0;
    intx_d = '0;
    dma_d  = 1'b0;
    unique case (irq_mode_e'(mode_i))
      MODE_ONE_LINE:   comb_d = err_i | (|pend_i) | dma_i;
      MODE_ONE_PLUS_D: begin
        comb_d = err_i | (|pend_i);
        dma_d  = dma_i;
      end
      MODE_PER_PIN: begin
        intx_d    = pend_i;
        intx_d[0] = pend_i[0] | err_i | dma_i;
      end
      MODE_PIN_PLUS_D: begin
        intx_d    = pend_i;
        intx_d[0] = pend_i[0] | err_i;
        dma_d     = dma_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_comb_o <= 1'b0;
      irq_intx_o <= '0;
      irq_dma_o  <= 1'b0;
    end else begin
      irq_comb_o <= comb_d;
      irq_intx_o <= intx_d;
      irq_dma_o  <= dma_d;
    end
  end

  // R11 R12: split modes never use the shared line
  p_comb_split_r11: assert property (@(posedge clk) disable iff (rst)
    mode_i[1] |=> !irq_comb_o);
  // R9 R11: even modes keep the DMA line idle
  p_dma_even_r9: assert property (@(posedge clk) disable iff (rst)
    !mode_i[0] |=> !irq_dma_o);
  // R9 R10: shared modes keep the per-pin lines idle
  p_intx_shared_r10: assert property (@(posedge clk) disable iff (rst)
    !mode_i[1] |=> irq_intx_o == '0);
  // R12: error rides on the first pin line in split modes
  p_err_inta_r12: assert property (@(posedge clk) disable iff (rst)
    (mode_i[1] && err_i) |=> irq_intx_o[0]);
endmodule

// File: rtl/hbr_irq_csr.sv
module hbr_irq_csr
  import hbr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [7:0]  CTRL_OFS   = 8'h00,
  parameter logic [7:0]  STAT_OFS   = 8'h04,
  parameter logic        CAP_HOST   = 1'b0,
  parameter logic        CAP_MASTER = 1'b1,
  parameter logic        CAP_TARGET = 1'b1,
  parameter logic        CAP_DMA    = 1'b1,
  parameter logic        CAP_TRACE  = 1'b0,
  parameter logic [2:0]  FIFO_DEPTH = 3'd4,
  parameter logic [1:0]  FIFO_COUNT = 2'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        irq_mode_i,
  input  logic [3:0]        intx_n_i,
  input  logic [5:0]        ev_pulse_i,
  input  logic              cfg_done_i,
  input  logic              cfg_err_i,
  output logic              irq_comb_o,
  output logic [3:0]        irq_intx_o,
  output logic              irq_dma_o,
  output logic              bus_reset_o,
  output logic [7:0]        bus_num_o,
  output logic              err_resp_en_o,
  output logic              par_en_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

  logic [WORD_W-1:0] ctrl_q;
  logic [NINTX-1:0]  lvl;
  logic [NFLAG-1:0]  flag, flag_set, flag_clr;
  logic [WORD_W-1:0] stat_w;
  logic              wr_ctrl, wr_stat, rd_en;
  logic [NINTX-1:0]  pend;
  logic              err_cond, dma_cond;

  assign wr_ctrl = bus_sel &  bus_wr & (bus_addr == A_CTRL);
  assign wr_stat = bus_sel &  bus_wr & (bus_addr == A_STAT);
  assign rd_en   = bus_sel & ~bus_wr;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
  end

  hbr_sync #(.W(NINTX), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d_i(intx_n_i), .q_o(lvl)
  );

  assign flag_set = {cfg_done_i, cfg_err_i, ev_pulse_i};
  assign flag_clr = wr_stat ? {bus_wdata[S_CFGDONE], bus_wdata[S_CFGERR],
                               bus_wdata[S_EVLO +: NEV]} : '0;

  hbr_sticky #(.N(NFLAG)) u_sticky (
    .clk(clk), .rst(rst), .set_i(flag_set), .clr_i(flag_clr), .flag_o(flag)
  );

  always_comb begin
    stat_w                  = '0;
    stat_w[31]              = CAP_HOST;
    stat_w[30]              = CAP_MASTER;
    stat_w[29]              = CAP_TARGET;
    stat_w[28]              = CAP_DMA;
    stat_w[25:24]           = irq_mode_i;
    stat_w[23]              = CAP_TRACE;
    stat_w[S_CFGDONE]       = flag[F_CDON];
    stat_w[S_CFGERR]        = flag[F_CERR];
    stat_w[S_EVLO +: NEV]   = flag[NEV-1:0];
    stat_w[S_LVLLO +: NINTX] = lvl;
    stat_w[4:2]             = FIFO_DEPTH;
    stat_w[1:0]             = FIFO_COUNT;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_en) begin
      if (bus_addr == A_CTRL)      bus_rdata <= ctrl_q;
      else if (bus_addr == A_STAT) bus_rdata <= stat_w;
      else                         bus_rdata <= '0;
    end
  end

  assign pend     = ~lvl & ctrl_q[NINTX-1:0];
  assign err_cond = (flag[F_SYS] & ctrl_q[C_SYSIE]) |
                    ((flag[F_MST] | flag[F_TGT] | flag[F_PAR]) & ctrl_q[C_ERRIE]);
  assign dma_cond = flag[F_DONE] | flag[F_DERR];

  hbr_route #(.NPIN(NINTX)) u_route (
    .clk(clk), .rst(rst), .mode_i(irq_mode_i), .pend_i(pend),
    .err_i(err_cond), .dma_i(dma_cond),
    .irq_comb_o(irq_comb_o), .irq_intx_o(irq_intx_o), .irq_dma_o(irq_dma_o)
  );

  assign bus_reset_o   = ctrl_q[C_BUSRST];
  assign bus_num_o     = ctrl_q[C_BUSLO +: 8];
  assign err_resp_en_o = ctrl_q[C_ERRRSP];
  assign par_en_o      = ctrl_q[C_PAREN];

  // R2: bus reset follows the written bit from the next cycle
  p_busrst_r2: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> bus_reset_o == $past(bus_wdata[31]));
  // R2: without a control write bus reset keeps its level
  p_busrst_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(bus_reset_o));
  // R1: unimplemented control bits read back as zero
  p_ctrl_rsvd_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr == A_CTRL) |=> bus_rdata[15:4] == '0);
  // R6: the mode field of a status read matches the strap
  p_mode_rd_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr == A_STAT) |=> bus_rdata[25:24] == $past(irq_mode_i));
endmodule

// File: tb/sim_hbr_irq_csr.sv
module sim_hbr_irq_csr;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_mode = 2'd0;
  logic [3:0]  intx_n = 4'hF;
  logic [5:0]  ev = '0;
  logic        cdone = 1'b0, cerr = 1'b0;
  logic        irq_comb, irq_dma, bus_reset, err_rsp, par_en;
  logic [3:0]  irq_intx;
  logic [7:0]  bus_num;

  int errors = 0;
  int checks = 0;
  bit started = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbr_irq_csr #(
    .ADDR_W(8), .CAP_HOST(1'b0), .CAP_MASTER(1'b1), .CAP_TARGET(1'b1),
    .CAP_DMA(1'b1), .CAP_TRACE(1'b0), .FIFO_DEPTH(3'd4), .FIFO_COUNT(2'd2)
  ) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_mode_i(irq_mode), .intx_n_i(intx_n), .ev_pulse_i(ev),
    .cfg_done_i(cdone), .cfg_err_i(cerr),
    .irq_comb_o(irq_comb), .irq_intx_o(irq_intx), .irq_dma_o(irq_dma),
    .bus_reset_o(bus_reset), .bus_num_o(bus_num),
    .err_resp_en_o(err_rsp), .par_en_o(par_en)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_ctrl;
  bit        m_sys, m_done, m_derr, m_mst, m_tgt, m_par, m_cdone, m_cerr;
  bit [3:0]  m_pipe[$];
  bit        m_comb, m_dma;
  bit [3:0]  m_intx;
  bit [31:0] m_rdata;
  int        m_last = 0;   // 0 ctrl/other, 1 status

  function automatic bit [31:0] model_status(bit [3:0] lvl, bit [1:0] md);
    bit [31:0] s = 32'h0;
    s[30] = 1'b1; s[29] = 1'b1; s[28] = 1'b1;
    s[25:24] = md;
    s[20] = m_cdone; s[19] = m_cerr;
    s[17] = m_sys; s[16] = m_done; s[15] = m_derr;
    s[14] = m_mst; s[13] = m_tgt; s[12] = m_par;
    s[11:8] = lvl;
    s[4:2] = 3'd4; s[1:0] = 2'd2;
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0;
      {m_sys, m_done, m_derr, m_mst, m_tgt, m_par, m_cdone, m_cerr} = '0;
      m_pipe = '{4'hF, 4'hF};
      m_comb = 0; m_dma = 0; m_intx = 0; m_rdata = 0; m_last = 0;
    end else begin
      bit [3:0] lvl;
      bit [3:0] pend;
      bit       err, dmac, anyp;
      lvl  = m_pipe[0];
      pend = ~lvl & m_ctrl[3:0];
      anyp = pend != 0;
      err  = (m_sys && m_ctrl[27]) || ((m_mst || m_tgt || m_par) && m_ctrl[25]);
      dmac = m_done || m_derr;
      m_comb = 0; m_dma = 0; m_intx = 0;
      if (irq_mode == 2'd0) m_comb = err || anyp || dmac;
      else if (irq_mode == 2'd1) begin m_comb = err || anyp; m_dma = dmac; end
      else if (irq_mode == 2'd2) begin m_intx = pend; m_intx[0] = pend[0] || err || dmac; end
      else begin m_intx = pend; m_intx[0] = pend[0] || err; m_dma = dmac; end
      if (bus_sel && !bus_wr) begin
        if (bus_addr == 8'h00) begin m_rdata = m_ctrl; m_last = 0; end
        else if (bus_addr == 8'h04) begin m_rdata = model_status(lvl, irq_mode); m_last = 1; end
        else begin m_rdata = 0; m_last = 0; end
      end
      if (bus_sel && bus_wr && bus_addr == 8'h04) begin
        if (bus_wdata[17]) m_sys = 0;
        if (bus_wdata[16]) m_done = 0;
        if (bus_wdata[15]) m_derr = 0;
        if (bus_wdata[14]) m_mst = 0;
        if (bus_wdata[13]) m_tgt = 0;
        if (bus_wdata[12]) m_par = 0;
        if (bus_wdata[20]) m_cdone = 0;
        if (bus_wdata[19]) m_cerr = 0;
      end
      if (ev[5]) m_sys = 1;
      if (ev[4]) m_done = 1;
      if (ev[3]) m_derr = 1;
      if (ev[2]) m_mst = 1;
      if (ev[1]) m_tgt = 1;
      if (ev[0]) m_par = 1;
      if (cdone) m_cdone = 1;
      if (cerr)  m_cerr = 1;
      if (bus_sel && bus_wr && bus_addr == 8'h00) m_ctrl = bus_wdata & 32'h8FFF_000F;
      void'(m_pipe.pop_front());
      m_pipe.push_back(intx_n);
    end
    started = 1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(bit [1:0] md);
    case (md)
      2'd0: return "R9 (R7 R8 R13)";
      2'd1: return "R10 (R7 R8 R13)";
      2'd2: return "R11 (R7 R8 R13)";
      default: return "R12 (R7 R8 R13)";
    endcase
  endfunction

  // compare every output on the falling edge
  always @(negedge clk) begin
    if (started && !finished) begin
      string t;
      t = mode_tag(irq_mode);
      chk({t, " irq_comb"}, {31'd0, irq_comb}, {31'd0, m_comb});
      chk({t, " irq_intx"}, {28'd0, irq_intx}, {28'd0, m_intx});
      chk({t, " irq_dma"},  {31'd0, irq_dma},  {31'd0, m_dma});
      chk("R2 bus_reset", {31'd0, bus_reset}, {31'd0, m_ctrl[31]});
      chk("R2 ctrl fields", {22'd0, bus_num, err_rsp, par_en},
          {22'd0, m_ctrl[23:16], m_ctrl[24], m_ctrl[26]});
      if (m_last == 1) begin
        chk("R3 status events", {26'd0, bus_rdata[17:12]}, {26'd0, m_rdata[17:12]});
        chk("R4 cfg flags", {30'd0, bus_rdata[20:19]}, {30'd0, m_rdata[20:19]});
        chk("R5 pin levels", {28'd0, bus_rdata[11:8]}, {28'd0, m_rdata[11:8]});
        chk("R6 read-only fields", bus_rdata & 32'hFFE4_00FF, m_rdata & 32'hFFE4_00FF);
      end else begin
        chk("R1 readback", bus_rdata, m_rdata);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(bit [7:0] a);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic pulse(bit [7:0] v);
    @(negedge clk);
    {cdone, cerr, ev} = v;
    @(negedge clk);
    {cdone, cerr, ev} = '0;
  endtask

  initial begin
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    rd(8'h00);
    rd(8'h04);           // R5: reset levels read 1, R6 fields
    for (int m = 0; m < 4; m++) begin
      irq_mode = 2'(m);
      idle(2);
      wr(8'h00, 32'h0A00_000F | (32'(m + 1) << 16));
      rd(8'h00);
      rd(8'h04);
      intx_n = 4'b1110; idle(4); rd(8'h04);
      intx_n = 4'b0101; idle(4); rd(8'h04);
      wr(8'h00, 32'h0B00_0005);
      idle(4);
      intx_n = 4'h0; idle(4);
      intx_n = 4'hF; idle(3);
      for (int i = 0; i < 8; i++) begin
        pulse(8'(1 << i));
        idle(2);
        rd(8'h04);
        wr(8'h04, (i < 6) ? (32'h1 << (12 + i)) : (32'h1 << (13 + i)));
        rd(8'h04);
      end
      // set and clear in the same cycle: set wins (R3 R4)
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 8'h04; bus_wdata = 32'hFFFF_FFFF;
      {cdone, cerr, ev} = 8'hFF;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; {cdone, cerr, ev} = '0;
      rd(8'h04);
      wr(8'h04, 32'h0000_0000);   // zeros clear nothing
      rd(8'h04);
      wr(8'h04, 32'hFFFF_FFFF);   // all ones clear all (R6)
      rd(8'h04);
      // enables off: error flags must not raise lines (R8)
      wr(8'h00, 32'h0000_000F);
      pulse(8'h27); idle(3);
      wr(8'h00, 32'h0800_000F); idle(3);   // only system-error enable
      wr(8'h00, 32'h0200_000F); idle(3);   // only error enable
      wr(8'h04, 32'hFFFF_FFFF); idle(2);
      rd(8'h08);
      rd(8'h00);
    end
    // bus reset drive (R2)
    wr(8'h00, 32'h8000_0000); idle(5);
    wr(8'h00, 32'h0000_0000); idle(3);
    // random traffic
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      intx_n = 4'($urandom);
      {cdone, cerr, ev} = (($urandom % 4) == 0) ? 8'($urandom) : 8'h0;
      bus_sel = ($urandom % 3) == 0;
      bus_wr  = 1'($urandom);
      bus_addr = (($urandom % 5) == 0) ? 8'h0C : ((($urandom % 2) == 0) ? 8'h00 : 8'h04);
      bus_wdata = $urandom;
      if ((k % 150) == 149) irq_mode = 2'($urandom);
    end
    @(negedge clk);
    bus_sel = 0; {cdone, cerr, ev} = '0;
    idle(5);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R13 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule